// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This block is the integer ALU of a small datapath. Each cycle it takes a destination operand, a source operand, an operation code and a width select. It works on either the low byte or the full 16-bit word of the operands. It performs addition and subtraction, each with and without the stored carry, plus compare, increment, decrement and three bitwise logic operations. The result is combinational. A companion strobe tells the register file whether that result should be written back.

Six status flags are produced for the operation: carry, auxiliary carry, parity, zero, sign and overflow. They are captured in a flag register on the rising clock edge, but only when the flag write-enable input is high. The stored carry feeds the carry-consuming operations. The stored carry is also what increment and decrement preserve. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `bw_alu`

## Requirements
- R1: Operation codes on `op_i`: 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 CMP, 5 INC, 6 DEC, 7 AND, 8 OR, 9 XOR. ADD gives dst+src and SUB gives dst-src, both modulo the selected width. ADC also adds the stored carry, and SBB also subtracts it.
- R2: After an arithmetic operation, the carry flag is the carry out of the top bit of the selected width for additions, and the borrow for subtractions.
- R3: The auxiliary carry flag is the carry out of bit 3 for additions, and the borrow into bit 3 for subtractions.
- R4: The parity flag is 1 when bits 7..0 of the result hold an even number of ones. This holds in both byte and word mode.
- R5: The zero flag is set when the result of the selected width is zero. The sign flag equals the top bit of that result (bit 7 in byte mode, bit 15 in word mode).
- R6: The overflow flag is set when the two's-complement result does not fit in the selected width.
- R7: CMP sets all flags exactly as SUB would, and drives `res_we_o` low.
- R8: INC and DEC add or subtract one and update AF, PF, ZF, SF and OF. The carry flag keeps its previous value.
- R9: AND, OR and XOR clear CF, AF and OF, and set PF, ZF and SF from the result.
- R10: When `flag_we_i` is low, or the opcode is 10..15, the flags keep their values. For opcodes 10..15, `res_o` is zero and `res_we_o` is low.
- R11: In byte mode (`word_i`=0), only bits 7..0 of the operands are used, and `res_o[15:8]` is zero.
- R12: While reset is applied, all flags are zero. A flag update becomes visible on the outputs after the rising edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code (see R1) |
| word_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| dst_i | input | 16 | Destination (left) operand |
| src_i | input | 16 | Source (right) operand |
| flag_we_i | input | 1 | Allow the flag register to update on this edge |
| res_o | output | 16 | Combinational result |
| res_we_o | output | 1 | Result should be written back |
| cf_o | output | 1 | Carry flag |
| af_o | output | 1 | Auxiliary carry flag |
| pf_o | output | 1 | Parity flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |

## Verification
`res_o` and `res_we_o` are due in the same cycle the inputs are applied. The bench drives them at the falling edge and compares them one time unit later, before any clock edge. The flags are due one rising edge later. The bench's behavioural model updates its flag copy at that edge and compares every flag one time unit after it. This also covers the carry that ADC, SBB, INC and DEC read back from the register. Directed cases cover the carry, borrow, nibble, overflow and parity boundaries in both widths, and a seeded random run mixes every opcode, width and write-enable setting.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_CMP = 4'd4,
    OP_INC = 4'd5,
    OP_DEC = 4'd6,
    OP_AND = 4'd7,
    OP_OR  = 4'd8,
    OP_XOR = 4'd9
  } alu_op_e;

  typedef struct packed {
    logic cf;
    logic af;
    logic pf;
    logic zf;
    logic sf;
    logic of;
  } alu_flags_t;
endpackage

// File: rtl/bw_alu_addsub.sv
module bw_alu_addsub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  input  logic          word_i,
  output logic [DW-1:0] sum_o,
  output logic          co_o,
  output logic          ac_o,
  output logic          ov_o
);
  localparam int HW = DW / 2;

  logic [DW:0] full;
  logic        a_top, b_top, r_top;

  always_comb begin
    if (sub_i) full = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cin_i};
    else       full = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
    sum_o = full[DW-1:0];
    co_o  = word_i ? full[DW] : full[HW];
    ac_o  = a_i[4] ^ b_i[4] ^ full[4];
    a_top = word_i ? a_i[DW-1] : a_i[HW-1];
    b_top = word_i ? b_i[DW-1] : b_i[HW-1];
    r_top = word_i ? full[DW-1] : full[HW-1];
    if (sub_i) ov_o = (a_top != b_top) && (r_top != a_top);
    else       ov_o = (a_top == b_top) && (r_top != a_top);
  end
endmodule

// File: rtl/bw_alu_logic.sv
module bw_alu_logic #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [1:0]    fn_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      2'd0:    y_o = a_i & b_i;
      2'd1:    y_o = a_i | b_i;
      default: y_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/bw_alu_flagreg.sv
module bw_alu_flagreg
  import bw_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  alu_flags_t d_i,
  output alu_flags_t q_o
);
  alu_flags_t q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (en_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_nxt;
  end
endmodule

// File: rtl/bw_alu.sv
module bw_alu
  import bw_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_i,
  input  logic          word_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] src_i,
  input  logic          flag_we_i,
  output logic [DW-1:0] res_o,
  output logic          res_we_o,
  output logic          cf_o,
  output logic          af_o,
  output logic          pf_o,
  output logic          zf_o,
  output logic          sf_o,
  output logic          of_o
);
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] LOW_MASK = {{(DW-HW){1'b0}}, {HW{1'b1}}};
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  alu_flags_t flg_q, flg_d;
  logic [DW-1:0] mask, a_m, b_m, as_b;
  logic [DW-1:0] sum, lres, res_raw, res_m;
  logic          as_cin, as_sub, co, ac, ov;
  logic          valid, is_arith, keep_cf;
  logic [1:0]    lfn;

  assign mask = word_i ? {DW{1'b1}} : LOW_MASK;
  assign a_m  = dst_i & mask;
  assign b_m  = src_i & mask;

  always_comb begin
    as_b     = b_m;
    as_cin   = 1'b0;
    as_sub   = 1'b0;
    valid    = 1'b1;
    is_arith = 1'b1;
    keep_cf  = 1'b0;
    lfn      = 2'd0;
    case (op_i)
      OP_ADD: ;
      OP_ADC: as_cin = flg_q.cf;
      OP_SUB: as_sub = 1'b1;
      OP_SBB: begin as_sub = 1'b1; as_cin = flg_q.cf; end
      OP_CMP: as_sub = 1'b1;
      OP_INC: begin as_b = ONE; keep_cf = 1'b1; end
      OP_DEC: begin as_b = ONE; as_sub = 1'b1; keep_cf = 1'b1; end
      OP_AND: begin is_arith = 1'b0; lfn = 2'd0; end
      OP_OR:  begin is_arith = 1'b0; lfn = 2'd1; end
      OP_XOR: begin is_arith = 1'b0; lfn = 2'd2; end
      default: begin valid = 1'b0; is_arith = 1'b0; end
    endcase
  end

  bw_alu_addsub #(.DW(DW)) u_addsub (
    .a_i(a_m), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub), .word_i(word_i),
    .sum_o(sum), .co_o(co), .ac_o(ac), .ov_o(ov)
  );

  bw_alu_logic #(.DW(DW)) u_logic (
    .a_i(a_m), .b_i(b_m), .fn_i(lfn), .y_o(lres)
  );

  assign res_raw  = is_arith ? sum : lres;
  assign res_m    = valid ? (res_raw & mask) : '0;
  assign res_o    = res_m;
  assign res_we_o = valid && (op_i != OP_CMP);

  always_comb begin
    flg_d.pf = ~^res_m[7:0];
    flg_d.zf = (res_m == '0);
    flg_d.sf = word_i ? res_m[DW-1] : res_m[HW-1];
    if (is_arith) begin
      flg_d.cf = keep_cf ? flg_q.cf : co;
      flg_d.af = ac;
      flg_d.of = ov;
    end else begin
      flg_d.cf = 1'b0;
      flg_d.af = 1'b0;
      flg_d.of = 1'b0;
    end
  end

  bw_alu_flagreg u_flags (
    .clk(clk), .rst_n(rst_int_n), .en_i(flag_we_i && valid),
    .d_i(flg_d), .q_o(flg_q)
  );

  assign cf_o = flg_q.cf;
  assign af_o = flg_q.af;
  assign pf_o = flg_q.pf;
  assign zf_o = flg_q.zf;
  assign sf_o = flg_q.sf;
  assign of_o = flg_q.of;
endmodule

// File: rtl/bw_alu_chk.sv
module bw_alu_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op_i,
  input logic          word_i,
  input logic          flag_we_i,
  input logic [DW-1:0] res_o,
  input logic          res_we_o,
  input logic          cf_o,
  input logic          af_o,
  input logic          pf_o,
  input logic          zf_o,
  input logic          sf_o,
  input logic          of_o
);
  localparam int HW = DW / 2;

  assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd4) |-> !res_we_o);

  assert_hold_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_we_i || op_i > 4'd9) |=>
      $stable({cf_o, af_o, pf_o, zf_o, sf_o, of_o}));

  assert_incdec_keep_cf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && (op_i == 4'd5 || op_i == 4'd6)) |=> (cf_o == $past(cf_o)));

  assert_logic_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && op_i >= 4'd7 && op_i <= 4'd9) |=> (!cf_o && !af_o && !of_o));

  assert_byte_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !word_i |-> (res_o[DW-1:HW] == '0));

  assert_zero_not_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zf_o |-> !sf_o);
endmodule

bind bw_alu bw_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .word_i(word_i), .flag_we_i(flag_we_i),
  .res_o(res_o), .res_we_o(res_we_o), .cf_o(cf_o), .af_o(af_o), .pf_o(pf_o),
  .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o)
);

// File: tb/tb_bw_alu.sv
module tb_bw_alu;
  localparam int PERIOD = 10;

  logic        clk, rst_n, word_i, flag_we_i, res_we_o;
  logic [3:0]  op_i;
  logic [15:0] dst_i, src_i, res_o;
  logic        cf_o, af_o, pf_o, zf_o, sf_o, of_o;

  int n_chk = 0, n_bad = 0;
  int m_cf = 0, m_af = 0, m_pf = 0, m_zf = 0, m_sf = 0, m_of = 0;
  bit done = 0;

  bw_alu dut (.*);

  initial clk = 0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int got, int exp, string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic step(int op, bit w, int d, int s, bit we);
    int mask, half, a, b, c, full, r, sa, sb, sr, ncf, naf, nof;
    bit arith, sub, keep;
    string rt;
    @(negedge clk);
    op_i = op[3:0]; word_i = w; dst_i = d[15:0]; src_i = s[15:0]; flag_we_i = we;
    mask = w ? 32'hFFFF : 32'hFF;
    half = w ? 32'h8000 : 32'h80;
    a = d & mask; b = s & mask; c = 0;
    arith = (op <= 6); sub = (op == 2 || op == 3 || op == 4 || op == 6);
    keep = (op == 5 || op == 6);
    if (op == 1 || op == 3) c = m_cf;
    if (keep) b = 1;
    r = 0; ncf = 0; naf = 0; nof = 0;
    if (arith) begin
      sa = (a >= half) ? a - 2*half : a;
      sb = (b >= half) ? b - 2*half : b;
      if (sub) begin
        full = a - b - c; ncf = (full < 0);
        naf = (((a & 15) - (b & 15) - c) < 0);
        sr = sa - sb - c;
      end else begin
        full = a + b + c; ncf = (full > mask);
        naf = (((a & 15) + (b & 15) + c) > 15);
        sr = sa + sb + c;
      end
      r = full & mask;
      nof = (sr >= half) || (sr < -half);
    end else if (op == 7) r = a & b;
    else if (op == 8) r = a | b;
    else if (op == 9) r = a ^ b;
    if (op <= 3) rt = "R1"; else if (op == 4) rt = "R7";
    else if (op <= 6) rt = "R8"; else if (op <= 9) rt = "R9"; else rt = "R10";
    #1;
    chk(rt, res_o, r, "result");
    chk(rt, res_we_o, (op <= 9 && op != 4), "res_we");
    if (!w) chk("R11", res_o[15:8], 0, "byte upper");
    @(posedge clk);
    if (we && op <= 9) begin
      if (!keep) m_cf = ncf;
      m_af = naf; m_of = nof;
      m_pf = ($countones(r & 8'hFF) % 2 == 0);
      m_zf = (r == 0);
      m_sf = ((r & half) != 0);
    end
    #1;
    if (!we || op > 9) rt = "R10"; else rt = "";
    chk((rt != "") ? rt : (keep ? "R8" : "R2"), cf_o, m_cf, "CF");
    chk((rt != "") ? rt : "R3", af_o, m_af, "AF");
    chk((rt != "") ? rt : "R4", pf_o, m_pf, "PF");
    chk((rt != "") ? rt : "R5", zf_o, m_zf, "ZF");
    chk((rt != "") ? rt : "R5", sf_o, m_sf, "SF");
    chk((rt != "") ? rt : "R6", of_o, m_of, "OF");
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; op_i = 0; word_i = 0; dst_i = 0; src_i = 0; flag_we_i = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R12", {cf_o, af_o, pf_o, zf_o, sf_o, of_o}, 0, "reset flags");
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    step(0, 0, 16'h00FF, 16'h0001, 1);  // byte carry, nibble carry, zero
    step(1, 0, 16'h0010, 16'h0020, 1);  // ADC using stored carry
    step(0, 1, 16'h7FFF, 16'h0001, 1);  // word signed overflow
    step(0, 1, 16'hFFFF, 16'h0001, 1);  // word carry out
    step(3, 1, 16'h1000, 16'h0001, 1);  // SBB with stored borrow
    step(2, 0, 16'h0000, 16'h0001, 1);  // byte borrow
    step(2, 0, 16'h0080, 16'h0001, 1);  // byte signed overflow on subtract
    step(4, 1, 16'h1234, 16'h1234, 1);  // compare equal
    step(4, 1, 16'h0001, 16'h0002, 1);  // compare less
    step(4, 1, 16'h0005, 16'h0002, 1);  // compare greater
    step(0, 0, 16'h00F0, 16'h0010, 1);  // carry set for INC test
    step(5, 0, 16'h00FF, 16'h0000, 1);  // INC wraps, CF kept
    step(6, 1, 16'h0000, 16'h0000, 1);  // DEC wraps, CF kept
    step(7, 1, 16'hF0F0, 16'h0FF0, 1);
    step(8, 0, 16'hAB00, 16'h0081, 1);
    step(9, 1, 16'h0100, 16'h0000, 1);  // parity on low byte only (R4)
    step(0, 0, 16'h00FF, 16'h0001, 0);  // flag write disabled
    step(12, 1, 16'h1111, 16'h2222, 1); // reserved opcode
    for (int i = 0; i < 400; i++)
      step($urandom % 16, $urandom % 2, $urandom % 65536, $urandom % 65536,
           ($urandom % 4) != 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule